// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block evaluates a set of Boolean functions written in sum-of-products form. It has a parameterised number of inputs, product terms and outputs. A first plane of storage gives each product term one literal code per input. The code says whether the input enters the term as itself, enters it inverted, stays out of the term, or blocks the term. A second plane holds one connection row per product term, and that row says which outputs the term drives. Every output is the OR of the product terms connected to it. Because of this, a single term can drive any number of outputs and is never duplicated.

The function itself is purely combinational from `in_vec` to `out_vec`. The array contents, which together form its personality, are written one product term at a time through a configuration port with a valid/ready handshake. A write is accepted on a rising clock edge where `cfg_valid` and `cfg_ready` are both high. The writer must hold the term index and both rows steady until that edge. `cfg_ready` stays low while reset is asserted and rises at the first clock edge after reset is released; after that it stays high, so the port never applies back-pressure in normal operation. Reset clears both planes.

Top module: `pla_array`

## Requirements
- R1: While reset is asserted, and directly after it is released, `out_vec` is all zeros for every input value.
- R2: Literal code 2'b01 in bits [2i+1:2i] of `cfg_and` makes input i enter the term uncomplemented.
- R3: Literal code 2'b10 in bits [2i+1:2i] of `cfg_and` makes input i enter the term complemented.
- R4: Literal code 2'b00 removes input i from the term. A term in which no input takes part evaluates to 1.
- R5: Literal code 2'b11 forces the term to 0 for every input value.
- R6: Bit j of `cfg_or` connects the written term to output j. An output with no connected term is 0.
- R7: A term connected to several outputs drives each of them. Each output is the OR of all of its connected terms.
- R8: A write changes `out_vec` only after the rising edge on which `cfg_valid` and `cfg_ready` are both high. While `cfg_valid` is low, the write fields have no effect.
- R9: A write whose `cfg_term` is not below the number of product terms changes no stored row.
- R10: `cfg_ready` is low during reset and during the first cycle after release, and high from the following clock edge on.
- R11: `out_vec` follows changes on `in_vec` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration storage |
| rst_n | input | 1 | Asynchronous active-low reset that clears both planes |
| cfg_valid | input | 1 | A configuration write is offered |
| cfg_ready | output | 1 | The configuration port accepts writes |
| cfg_term | input | TERM_W | Index of the product term being written |
| cfg_and | input | 2*N_IN | Literal codes, two bits per input, input i at [2i+1:2i] |
| cfg_or | input | N_OUT | Output connection row, bit j for output j |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
Single-term personalities driven from one output are run over every input value. They separate the four literal codes, because each code gives a different truth table: follow, invert, constant 1 and constant 0. An always-true term drives a chosen set of outputs, and a second term is added on top of it. This separates the connection bits from each other and shows that terms are ORed and shared. The full three-input reference personality, with five shared terms and four outputs, is then swept across all eight input values and compared with the equations computed in the bench. Out-of-range indices, writes with `cfg_valid` low, and the output value just before and just after the accepting edge separate correct write decoding from aliasing and early updates.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_SKIP  = 2'b00,
    LIT_TRUE  = 2'b01,
    LIT_INV   = 2'b10,
    LIT_BLOCK = 2'b11
  } lit_code_e;

  function automatic logic lit_pass(input logic [1:0] code, input logic val);
    case (lit_code_e'(code))
      LIT_SKIP: lit_pass = 1'b1;
      LIT_TRUE: lit_pass = val;
      LIT_INV:  lit_pass = ~val;
      default:  lit_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pla_cfg_port.sv
module pla_cfg_port #(
  parameter int N_TERM = 5,
  parameter int TERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [TERM_W-1:0] cfg_term,
  output logic              cfg_ready,
  output logic [N_TERM-1:0] term_we
);

  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign cfg_ready = ready_q;

  for (genvar t = 0; t < N_TERM; t++) begin : g_dec
    assign term_we[t] = cfg_valid && ready_q && (cfg_term == TERM_W'(t));
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TERM-1:0] term_we,
  input  logic [2*N_IN-1:0] wr_row,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_TERM-1:0] term_vec
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [2*N_IN-1:0] row_q;
    logic [N_IN-1:0]   lit_ok;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          row_q <= '0;
      else if (term_we[t]) row_q <= wr_row;
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit_ok[i] = lit_pass(row_q[2*i+1:2*i], in_vec[i]);
    end

    assign term_vec[t] = &lit_ok;
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TERM-1:0] term_we,
  input  logic [N_OUT-1:0]  wr_row,
  input  logic [N_TERM-1:0] term_vec,
  output logic [N_OUT-1:0]  out_vec
);

  logic [N_OUT-1:0] conn_q [N_TERM];

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          conn_q[t] <= '0;
      else if (term_we[t]) conn_q[t] <= wr_row;
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] col;
    for (genvar t = 0; t < N_TERM; t++) begin : g_col
      assign col[t] = conn_q[t][j];
    end
    assign out_vec[j] = |(col & term_vec);
  end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  localparam int TERM_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [TERM_W-1:0] cfg_term,
  input  logic [2*N_IN-1:0] cfg_and,
  input  logic [N_OUT-1:0]  cfg_or,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);

  logic [N_TERM-1:0] term_we;
  logic [N_TERM-1:0] term_vec;

  pla_cfg_port #(.N_TERM(N_TERM), .TERM_W(TERM_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_term(cfg_term),
    .cfg_ready(cfg_ready), .term_we(term_we)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk(clk), .rst_n(rst_n), .term_we(term_we), .wr_row(cfg_and),
    .in_vec(in_vec), .term_vec(term_vec)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst_n(rst_n), .term_we(term_we), .wr_row(cfg_or),
    .term_vec(term_vec), .out_vec(out_vec)
  );

endmodule

// File: rtl/pla_array_checker.sv
module pla_array_checker #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  parameter int TERM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [TERM_W-1:0] cfg_term,
  input logic [N_IN-1:0]   in_vec,
  input logic [N_OUT-1:0]  out_vec
);

  // R10: ready stays low during the first cycle after release
  a_r10_not_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !cfg_ready);

  // R10: ready is high from the second edge after release onward
  a_r10_ready_later: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cfg_ready);

  // R1: planes are empty right after reset release
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (out_vec == '0));

  // R8: without an accepted write and with steady inputs, outputs hold
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_valid && cfg_ready) && $stable(in_vec)) |-> $stable(out_vec));

  // R9: an out-of-range write leaves outputs unchanged
  a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_valid && (int'(cfg_term) >= N_TERM)) && $stable(in_vec))
      |-> $stable(out_vec));

endmodule

bind pla_array pla_array_checker #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TERM_W(TERM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_term(cfg_term), .in_vec(in_vec), .out_vec(out_vec)
);

// File: tb/pla_array_tb_top.sv
module pla_array_tb_top;

  localparam int N_IN = 3, N_TERM = 5, N_OUT = 4, TERM_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_valid = 1'b0;
  logic              cfg_ready;
  logic [TERM_W-1:0] cfg_term = '0;
  logic [2*N_IN-1:0] cfg_and = '0;
  logic [N_OUT-1:0]  cfg_or = '0;
  logic [N_IN-1:0]   in_vec = '0;
  logic [N_OUT-1:0]  out_vec;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pla_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_term(cfg_term), .cfg_and(cfg_and), .cfg_or(cfg_or),
    .in_vec(in_vec), .out_vec(out_vec)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs: in_vec = {A, B, C}
  function automatic logic [3:0] ref_eq(input logic [2:0] v);
    logic a, b, c;
    {a, b, c} = v;
    ref_eq[0] = a | (~b & ~c);
    ref_eq[1] = (a & ~c) | (a & b);
    ref_eq[2] = (~b & ~c) | (a & b);
    ref_eq[3] = (~b & c) | a;
  endfunction

  task automatic wr(input int term, input logic [5:0] arow, input logic [3:0] orow);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_term  = TERM_W'(term);
    cfg_and   = arow;
    cfg_or    = orow;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int t = 0; t < N_TERM; t++) wr(t, 6'b111111, 4'b0000);
  endtask

  task automatic set_in(input logic [2:0] v);
    in_vec = v;
    #1;
  endtask

  task automatic t_reset();
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check(out_vec == 4'b0, "R1 during reset", out_vec, 0);
    end
    check(cfg_ready == 1'b0, "R10 ready low in reset", cfg_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cfg_ready == 1'b0, "R10 ready low first cycle", cfg_ready, 0);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check(out_vec == 4'b0, "R1 after release", out_vec, 0);
    end
    @(negedge clk);
    check(cfg_ready == 1'b1, "R10 ready high", cfg_ready, 1);
  endtask

  task automatic t_literals();
    logic [3:0] exp;
    clear_all();
    wr(0, 6'b00_00_01, 4'b0001);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      exp = {3'b000, in_vec[0]};
      check(out_vec == exp, "R2 true literal", out_vec, exp);
    end
    wr(0, 6'b00_10_00, 4'b0001);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      exp = {3'b000, ~in_vec[1]};
      check(out_vec == exp, "R3 complemented literal", out_vec, exp);
    end
    wr(0, 6'b00_00_00, 4'b0001);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check(out_vec == 4'b0001, "R4 empty term is 1, R6 unconnected outputs 0", out_vec, 1);
    end
    wr(0, 6'b11_00_00, 4'b0001);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check(out_vec == 4'b0000, "R5 blocked term", out_vec, 0);
    end
  endtask

  task automatic t_or_plane();
    logic [3:0] exp;
    clear_all();
    wr(0, 6'b00_00_00, 4'b1010);
    set_in(3'b000);
    check(out_vec == 4'b1010, "R6 connection bits", out_vec, 4'b1010);
    wr(1, 6'b01_00_00, 4'b0101);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      exp = in_vec[2] ? 4'b1111 : 4'b1010;
      check(out_vec == exp, "R7 shared and ORed terms", out_vec, exp);
    end
  endtask

  task automatic t_timing();
    clear_all();
    set_in(3'b000);
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_term = 3'd2; cfg_and = 6'b000000; cfg_or = 4'b1111;
    @(negedge clk);
    check(out_vec == 4'b0000, "R8 valid low ignored", out_vec, 0);
    cfg_valid = 1'b1;
    #2;
    check(out_vec == 4'b0000, "R8 no change before edge", out_vec, 0);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    check(out_vec == 4'b1111, "R8 change after edge", out_vec, 4'b1111);
  endtask

  task automatic t_oob();
    clear_all();
    set_in(3'b000);
    for (int t = N_TERM; t < (1 << TERM_W); t++) begin
      wr(t, 6'b000000, 4'b1111);
      set_in(3'b000);
      check(out_vec == 4'b0000, "R9 out-of-range index ignored", out_vec, 0);
    end
  endtask

  task automatic t_reference();
    logic [3:0] exp;
    clear_all();
    wr(0, 6'b01_01_00, 4'b0110);
    wr(1, 6'b00_10_01, 4'b1000);
    wr(2, 6'b01_00_10, 4'b0010);
    wr(3, 6'b00_10_10, 4'b0101);
    wr(4, 6'b01_00_00, 4'b1001);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      exp = ref_eq(3'(v));
      check(out_vec == exp, "R7 R11 reference personality", out_vec, exp);
    end
    @(negedge clk);
    in_vec = 3'b011;
    #1;
    exp = ref_eq(3'b011);
    check(out_vec == exp, "R11 combinational response", out_vec, exp);
  endtask

  initial begin
    t_reset();
    t_literals();
    t_or_plane();
    t_timing();
    t_oob();
    t_reference();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule